// File: doc/BRIEF.md
# Display AUX Channel Request Controller

This block runs one AUX channel transaction at a time for a local requester. The requester asks for one of four things: a native read, a native write, an I2C-over-AUX read byte or an I2C-over-AUX write byte. The block builds the request frame and streams it byte by byte to a PHY model over a valid/ready interface. It then collects the reply data bytes and a reply status, and decodes the reply code in two layers. When a transaction ends, it reports a result code, the returned bytes and their count.

Busy channel statuses are retried at once. Deferrals, at either the native or the I2C layer, are retried after a fixed back-off of `BACKOFF_US` microseconds, counted in clock cycles derived from `CLK_HZ`. No request makes more than `MAX_TRIES` (4) attempts. While a transaction or a back-off is running, the block takes no new request.

Top module: `auxReqController`

## Requirements
- R1: A frame starts with four header bytes in this order: address bits 7:0, address bits 15:8, the command in bits 7:4 of the third byte with bits 3:0 zero, then the length byte. Command codes are 9 for native read, 8 for native write, 1 for I2C read and 0 for I2C write. `txByte` stays stable while `txValid` is high and `txReady` is low.
- R2: For a native request of N bytes, the length byte is {frame byte count mod 16, N-1}. A native read frame is 4 bytes. A native write frame is 4+N bytes, and wrData bytes 0..N-1 follow the header. No byte is sent after the frame.
- R3: `kind` encodes the request as 0 native read, 1 native write, 2 I2C read, 3 I2C write. A native request with `len` of 0 or more than 16 is rejected: one cycle later `done` pulses with result 4, and `txValid` and `busy` stay low.
- R4: An I2C request adds 4 to its command unless `i2cStop` is set. If `i2cStart` or `i2cStop` is set, the frame is 4 bytes with length byte 0x30. Otherwise an I2C read is 4 bytes with length byte 0x40, and an I2C write is 5 bytes with length byte 0x50 followed by wrData byte 0.
- R5: A reply status of 2 (busy) starts the next attempt in the following cycle, with no wait.
- R6: A reply status of 1 (timeout) ends the transaction with result 1. A status of 3 (channel error) ends it with result 3.
- R7: On status 0, the native reply field is `rxReply[5:4]`. Its values mean 0 ack, 1 nack, 2 defer and 3 reserved. A native defer holds `txValid` low for exactly BACKOFF_CYC cycles, then resends the same frame. A native nack ends the transaction with result 2.
- R8: A transaction makes at most 4 attempts. If the fourth attempt ends in busy or defer, the transaction ends with result 2 in the next cycle and there is no back-off.
- R9: The I2C field `rxReply[7:6]` uses the same values and is decoded only for I2C requests, and only after a native ack. I2C ack gives result 0, I2C nack gives result 2, and I2C defer backs off and retries. A reserved value in either field gives result 5.
- R10: Reply data bytes are stored in arrival order at `rdData[8k+:8]`. On result 0, `rdLen` is min(received, N) for a native read, min(received, 1) for an I2C read, and 0 for writes. On any other result `rdLen` is 0.
- R11: `busy` is high from the cycle after a request is accepted until `done`. A `start` seen while `busy` is high is ignored, and `txValid` is only ever high while `busy` is high.
- R12: `done` is a one-cycle pulse. `result`, `rdLen` and `rdData` hold their values until the next request is accepted. After reset, `busy`, `done`, `txValid`, `result` and `rdLen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| kind | input | 2 | Request kind |
| i2cStart | input | 1 | I2C start phase (address only) |
| i2cStop | input | 1 | I2C stop phase (address only, no MOT) |
| addr | input | 16 | Target address |
| len | input | LEN_W | Native byte count |
| wrData | input | MAX_BYTES*8 | Write payload, byte 0 in bits 7:0 |
| done | output | 1 | Transaction finished pulse |
| result | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 channel error, 4 rejected, 5 bad reply |
| rdData | output | MAX_BYTES*8 | Returned bytes |
| rdLen | output | LEN_W | Number of valid returned bytes |
| busy | output | 1 | Transaction or back-off in progress |
| txValid | output | 1 | Frame byte valid |
| txByte | output | 8 | Frame byte |
| txReady | input | 1 | PHY takes the byte |
| rxDataValid | input | 1 | Reply data byte valid |
| rxData | input | 8 | Reply data byte |
| rxStatusValid | input | 1 | Reply status valid, ends the attempt |
| rxStatus | input | 2 | 0 done, 1 timeout, 2 busy, 3 error |
| rxReply | input | 8 | Reply code byte |

## Verification
The hardest corner to reach is the fourth attempt. There, a defer or busy outcome has to end the transaction instead of starting a back-off, and getting there takes three earlier retries, each with its own frame, reply and wait. The bench drives a scripted PHY responder that gives every attempt its own status, reply code and data count, with `txReady` stalling every third cycle. A behavioural model walks the same script to predict each byte, gap length and final result. Mixed scripts also cover busy followed by defer followed by ack, an I2C-level defer that is hidden behind a native ack, and an I2C field value that must be ignored on a native request.

// File: rtl/auxReqPkg.sv
package auxReqPkg;

  typedef enum logic [1:0] {
    KIND_NAT_RD = 2'd0,
    KIND_NAT_WR = 2'd1,
    KIND_I2C_RD = 2'd2,
    KIND_I2C_WR = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_TIMEOUT  = 3'd1,
    RES_IOERR    = 3'd2,
    RES_CHERR    = 3'd3,
    RES_REJECT   = 3'd4,
    RES_BADREPLY = 3'd5
  } result_e;

  typedef enum logic [1:0] {
    ST_DONE    = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_BUSY    = 2'd2,
    ST_ERROR   = 2'd3
  } status_e;

  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;
  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT    = 4'h4;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic startAttempt;
    logic txAdvance;
    logic capture;
    logic startBackoff;
    logic backoffTick;
  } ctlStrobes_t;

endpackage

// File: rtl/auxReqDatapath.sv
module auxReqDatapath
  import auxReqPkg::*;
#(
  parameter int MAX_BYTES   = 16,
  parameter int BACKOFF_CYC = 50000,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int IDX_W = $clog2(MAX_BYTES + 5),
  localparam int PW    = $clog2(MAX_BYTES),
  localparam int BO_W  = $clog2(BACKOFF_CYC + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobes_t            ctl,
  input  logic [1:0]             kindIn,
  input  logic                   i2cStartIn,
  input  logic                   i2cStopIn,
  input  logic [15:0]            addrIn,
  input  logic [CNT_W-1:0]       lenIn,
  input  logic [MAX_BYTES*8-1:0] wrDataIn,
  input  logic [7:0]             rxData,
  output logic [7:0]             txByte,
  output logic                   txLastByte,
  output logic                   backoffDone,
  output logic                   reqIsI2c,
  output logic [CNT_W-1:0]       rxCount,
  output logic [MAX_BYTES*8-1:0] rxBuf
);

  logic [15:0]      addrR;
  kind_e            kindR;
  logic             startR, stopR;
  logic [CNT_W-1:0] lenR;
  logic [7:0]       wrBufR [MAX_BYTES];
  logic [7:0]       rxBufR [MAX_BYTES];
  logic [IDX_W-1:0] idxR;
  logic [CNT_W-1:0] cntR;
  logic [BO_W-1:0]  boCnt;

  logic [3:0]       cmdNib;
  logic [IDX_W-1:0] frameLen;
  logic [7:0]       lenByte;
  logic [CNT_W-1:0] lenM1;
  logic [IDX_W-1:0] payIdx;
  logic [CNT_W-1:0] capLimit;
  logic             addrOnly;

  assign reqIsI2c = kindR[1];
  assign addrOnly = kindR[1] && (startR || stopR);
  assign lenM1    = lenR - CNT_W'(1);
  assign payIdx   = idxR - IDX_W'(4);

  always_comb begin
    cmdNib   = CMD_NAT_RD;
    frameLen = IDX_W'(4);
    lenByte  = 8'h30;
    capLimit = '0;
    case (kindR)
      KIND_NAT_RD: begin
        cmdNib   = CMD_NAT_RD;
        capLimit = lenR;
        lenByte  = {frameLen[3:0], lenM1[3:0]};
      end
      KIND_NAT_WR: begin
        cmdNib   = CMD_NAT_WR;
        frameLen = IDX_W'(4) + IDX_W'(lenR);
        lenByte  = {frameLen[3:0], lenM1[3:0]};
      end
      KIND_I2C_RD: begin
        cmdNib   = stopR ? CMD_I2C_RD : (CMD_I2C_RD | CMD_MOT);
        capLimit = CNT_W'(1);
        lenByte  = addrOnly ? 8'h30 : 8'h40;
      end
      default: begin
        cmdNib   = stopR ? CMD_I2C_WR : (CMD_I2C_WR | CMD_MOT);
        frameLen = addrOnly ? IDX_W'(4) : IDX_W'(5);
        lenByte  = addrOnly ? 8'h30 : 8'h50;
      end
    endcase
  end

  always_comb begin
    case (idxR)
      IDX_W'(0): txByte = addrR[7:0];
      IDX_W'(1): txByte = addrR[15:8];
      IDX_W'(2): txByte = {cmdNib, 4'h0};
      IDX_W'(3): txByte = lenByte;
      default:   txByte = wrBufR[payIdx[PW-1:0]];
    endcase
  end

  assign txLastByte  = (idxR == frameLen - IDX_W'(1));
  assign backoffDone = (boCnt == '0);
  assign rxCount     = cntR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR  <= '0;
      kindR  <= KIND_NAT_RD;
      startR <= 1'b0;
      stopR  <= 1'b0;
      lenR   <= '0;
      idxR   <= '0;
      cntR   <= '0;
      boCnt  <= '0;
      for (int i = 0; i < MAX_BYTES; i++) begin
        wrBufR[i] <= '0;
        rxBufR[i] <= '0;
      end
    end else begin
      if (ctl.loadReq) begin
        addrR  <= addrIn;
        kindR  <= kind_e'(kindIn);
        startR <= i2cStartIn;
        stopR  <= i2cStopIn;
        lenR   <= lenIn;
        for (int i = 0; i < MAX_BYTES; i++) wrBufR[i] <= wrDataIn[i*8 +: 8];
      end
      if (ctl.loadReq || ctl.startAttempt) begin
        idxR <= '0;
        cntR <= '0;
        for (int i = 0; i < MAX_BYTES; i++) rxBufR[i] <= '0;
      end else begin
        if (ctl.txAdvance) idxR <= idxR + IDX_W'(1);
        if (ctl.capture && (cntR < capLimit)) begin
          rxBufR[cntR[PW-1:0]] <= rxData;
          cntR <= cntR + CNT_W'(1);
        end
      end
      if (ctl.startBackoff) boCnt <= BO_W'(BACKOFF_CYC - 1);
      else if (ctl.backoffTick) boCnt <= boCnt - BO_W'(1);
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_rxFlat
    assign rxBuf[g*8 +: 8] = rxBufR[g];
  end

endmodule

// File: rtl/auxReqControl.sv
module auxReqControl
  import auxReqPkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int MAX_TRIES = 4,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       kindIn,
  input  logic [CNT_W-1:0] lenIn,
  input  logic             txReady,
  input  logic             txLastByte,
  input  logic             rxDataValid,
  input  logic             rxStatusValid,
  input  logic [1:0]       rxStatus,
  input  logic [7:0]       rxReply,
  input  logic             backoffDone,
  input  logic             reqIsI2c,
  output ctlStrobes_t      ctl,
  output logic             txValid,
  output logic             busy,
  output logic             done,
  output logic             inWait,
  output result_e          result
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_BACKOFF} state_e;

  state_e           state;
  logic [TRY_W-1:0] tries;
  logic             reqBad, lastTry;
  logic             finNow, retryNow, retryWait;
  result_e          finRes;

  assign reqBad  = !kindIn[1] && ((lenIn == '0) || (lenIn > CNT_W'(MAX_BYTES)));
  assign lastTry = (tries == TRY_W'(MAX_TRIES));

  always_comb begin
    finNow = 1'b0; retryNow = 1'b0; retryWait = 1'b0; finRes = RES_OK;
    if (state == S_WAIT && rxStatusValid) begin
      case (status_e'(rxStatus))
        ST_BUSY:    retryNow = 1'b1;
        ST_TIMEOUT: begin finNow = 1'b1; finRes = RES_TIMEOUT; end
        ST_ERROR:   begin finNow = 1'b1; finRes = RES_CHERR; end
        default: begin
          case (rxReply[5:4])
            2'd1: begin finNow = 1'b1; finRes = RES_IOERR; end
            2'd2: retryWait = 1'b1;
            2'd3: begin finNow = 1'b1; finRes = RES_BADREPLY; end
            default: begin
              if (!reqIsI2c) finNow = 1'b1;
              else begin
                case (rxReply[7:6])
                  2'd0: finNow = 1'b1;
                  2'd1: begin finNow = 1'b1; finRes = RES_IOERR; end
                  2'd2: retryWait = 1'b1;
                  default: begin finNow = 1'b1; finRes = RES_BADREPLY; end
                endcase
              end
            end
          endcase
        end
      endcase
      if ((retryNow || retryWait) && lastTry) begin
        retryNow = 1'b0; retryWait = 1'b0;
        finNow = 1'b1; finRes = RES_IOERR;
      end
    end
  end

  always_comb begin
    ctl.loadReq      = (state == S_IDLE) && start && !reqBad;
    ctl.startAttempt = retryNow || ((state == S_BACKOFF) && backoffDone);
    ctl.txAdvance    = (state == S_SEND) && txReady && !txLastByte;
    ctl.capture      = (state == S_WAIT) && rxDataValid;
    ctl.startBackoff = retryWait;
    ctl.backoffTick  = (state == S_BACKOFF) && !backoffDone;
  end

  assign txValid = (state == S_SEND);
  assign busy    = (state != S_IDLE);
  assign inWait  = (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tries  <= '0;
      done   <= 1'b0;
      result <= RES_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (reqBad) begin
            done   <= 1'b1;
            result <= RES_REJECT;
          end else begin
            state <= S_SEND;
            tries <= TRY_W'(1);
          end
        end
        S_SEND: if (txReady && txLastByte) state <= S_WAIT;
        S_WAIT: begin
          if (finNow) begin
            state  <= S_IDLE;
            done   <= 1'b1;
            result <= finRes;
          end else if (retryNow) begin
            state <= S_SEND;
            tries <= tries + TRY_W'(1);
          end else if (retryWait) begin
            state <= S_BACKOFF;
          end
        end
        default: if (backoffDone) begin
          state <= S_SEND;
          tries <= tries + TRY_W'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/auxReqController.sv
module auxReqController
  import auxReqPkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int BACKOFF_US = 400,
  parameter int MAX_BYTES  = 16,
  parameter int MAX_TRIES  = 4,
  localparam int BACKOFF_CYC = (CLK_HZ / 1_000_000) * BACKOFF_US,
  localparam int LEN_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             kind,
  input  logic                   i2cStart,
  input  logic                   i2cStop,
  input  logic [15:0]            addr,
  input  logic [LEN_W-1:0]       len,
  input  logic [MAX_BYTES*8-1:0] wrData,
  output logic                   done,
  output logic [2:0]             result,
  output logic [MAX_BYTES*8-1:0] rdData,
  output logic [LEN_W-1:0]       rdLen,
  output logic                   busy,
  output logic                   txValid,
  output logic [7:0]             txByte,
  input  logic                   txReady,
  input  logic                   rxDataValid,
  input  logic [7:0]             rxData,
  input  logic                   rxStatusValid,
  input  logic [1:0]             rxStatus,
  input  logic [7:0]             rxReply
);

  ctlStrobes_t      ctl;
  logic             txLastByte, backoffDone, reqIsI2c, inWait;
  logic [LEN_W-1:0] rxCount;
  result_e          resultE;

  auxReqControl #(.MAX_BYTES(MAX_BYTES), .MAX_TRIES(MAX_TRIES)) u_control (
    .clk(clk), .rstN(rstN), .start(start), .kindIn(kind), .lenIn(len),
    .txReady(txReady), .txLastByte(txLastByte), .rxDataValid(rxDataValid),
    .rxStatusValid(rxStatusValid), .rxStatus(rxStatus), .rxReply(rxReply),
    .backoffDone(backoffDone), .reqIsI2c(reqIsI2c), .ctl(ctl),
    .txValid(txValid), .busy(busy), .done(done), .inWait(inWait), .result(resultE)
  );

  auxReqDatapath #(.MAX_BYTES(MAX_BYTES), .BACKOFF_CYC(BACKOFF_CYC)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .kindIn(kind), .i2cStartIn(i2cStart),
    .i2cStopIn(i2cStop), .addrIn(addr), .lenIn(len), .wrDataIn(wrData),
    .rxData(rxData), .txByte(txByte), .txLastByte(txLastByte),
    .backoffDone(backoffDone), .reqIsI2c(reqIsI2c), .rxCount(rxCount), .rxBuf(rdData)
  );

  assign result = resultE;
  assign rdLen  = (resultE == RES_OK) ? rxCount : '0;

endmodule

// File: rtl/auxReqChecker.sv
module auxReqChecker #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       kind,
  input logic [LEN_W-1:0] len,
  input logic             busy,
  input logic             done,
  input logic [2:0]       result,
  input logic             txValid,
  input logic             txReady,
  input logic [7:0]       txByte,
  input logic             rxStatusValid,
  input logic [1:0]       rxStatus,
  input logic             inWait
);

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte));

  // R3
  reject_no_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start && !kind[1] && ((len == '0) || (len > LEN_W'(MAX_BYTES)))
    |=> done && (result == 3'd4) && !busy && !txValid);

  // R5
  busy_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWait && rxStatusValid && (rxStatus == 2'd2) |=> txValid || (done && (result == 3'd2)));

  // R6
  timeout_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWait && rxStatusValid && (rxStatus == 2'd1) |=> done && (result == 3'd1) && !busy);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  tx_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy);

endmodule

bind auxReqController auxReqChecker #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_checker (
  .clk(clk), .rstN(rstN), .start(start), .kind(kind), .len(len), .busy(busy),
  .done(done), .result(result), .txValid(txValid), .txReady(txReady), .txByte(txByte),
  .rxStatusValid(rxStatusValid), .rxStatus(rxStatus), .inWait(inWait)
);

// File: tb/test_auxReqController.sv
module test_auxReqController;

  localparam int CLK_HZ = 125_000_000;
  localparam int BO_US  = 2;
  localparam int MAXB   = 16;
  localparam int BO_CYC = (CLK_HZ / 1_000_000) * BO_US;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, i2cStart = 1'b0, i2cStop = 1'b0;
  logic [1:0] kind = '0;
  logic [15:0] addr = '0;
  logic [4:0] len = '0;
  logic [MAXB*8-1:0] wrData = '0;
  logic done, busy, txValid;
  logic [2:0] result;
  logic [MAXB*8-1:0] rdData;
  logic [4:0] rdLen;
  logic [7:0] txByte;
  logic txReady = 1'b0, rxDataValid = 1'b0, rxStatusValid = 1'b0;
  logic [7:0] rxData = '0, rxReply = '0;
  logic [1:0] rxStatus = '0;

  auxReqController #(.CLK_HZ(CLK_HZ), .BACKOFF_US(BO_US), .MAX_BYTES(MAXB), .MAX_TRIES(4))
  i_auxReqController (
    .clk(clk), .rstN(rstN), .start(start), .kind(kind), .i2cStart(i2cStart),
    .i2cStop(i2cStop), .addr(addr), .len(len), .wrData(wrData), .done(done),
    .result(result), .rdData(rdData), .rdLen(rdLen), .busy(busy), .txValid(txValid),
    .txByte(txByte), .txReady(txReady), .rxDataValid(rxDataValid), .rxData(rxData),
    .rxStatusValid(rxStatusValid), .rxStatus(rxStatus), .rxReply(rxReply)
  );

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  int sSt[4], sRep[4], sN[4];

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dv(input int a, input int i);
    return 8'((a + 1) * 16 + i * 7 + 1);
  endfunction

  task automatic setAtt(input int a, input int st, input int rep, input int n);
    sSt[a] = st; sRep[a] = rep; sN[a] = n;
  endtask

  // expected frame from R1, R2, R4
  task automatic buildFrame(input int kd, input bit st, input bit sp, input int ad,
                            input int ln, input logic [MAXB*8-1:0] wd, ref logic [7:0] q[$]);
    int cmd, fl;
    q = {};
    q.push_back(8'(ad & 255));
    q.push_back(8'((ad >> 8) & 255));
    case (kd)
      0: cmd = 9;
      1: cmd = 8;
      2: cmd = sp ? 1 : 5;
      default: cmd = sp ? 0 : 4;
    endcase
    q.push_back(8'(cmd << 4));
    if (kd < 2) begin
      fl = (kd == 1) ? 4 + ln : 4;
      q.push_back(8'(((fl % 16) << 4) | (ln - 1)));
      if (kd == 1) for (int i = 0; i < ln; i++) q.push_back(wd[i*8 +: 8]);
    end else if (st || sp) q.push_back(8'h30);
    else if (kd == 2) q.push_back(8'h40);
    else begin
      q.push_back(8'h50);
      q.push_back(wd[7:0]);
    end
  endtask

  // act: 0 finish, 1 retry now, 2 retry after back-off (R5..R9)
  task automatic judge(input int s, input int rep, input bit i2c, output int act, output int res);
    int nat, ic;
    act = 0; res = 0;
    nat = (rep >> 4) & 3; ic = (rep >> 6) & 3;
    if (s == 2) act = 1;
    else if (s == 1) res = 1;
    else if (s == 3) res = 3;
    else if (nat == 1) res = 2;
    else if (nat == 2) act = 2;
    else if (nat == 3) res = 5;
    else if (i2c) begin
      if (ic == 1) res = 2;
      else if (ic == 2) act = 2;
      else if (ic == 3) res = 5;
    end
  endtask

  task automatic doTxn(input string tag, input int kd, input bit st, input bit sp,
                       input int ad, input int ln, input logic [MAXB*8-1:0] wd, input bit holdStart);
    logic [7:0] q[$];
    int act, res, k, cnt, expLen;
    buildFrame(kd, st, sp, ad, ln, wd, q);
    @(negedge clk);
    kind = 2'(kd); i2cStart = st; i2cStop = sp; addr = 16'(ad); len = 5'(ln);
    wrData = wd; start = 1'b1;
    @(negedge clk);
    start = holdStart;
    if (holdStart) begin kind = 2'd0; len = 5'd0; addr = 16'hFFFF; end
    for (int a = 0; a < 4; a++) begin
      k = 0; cnt = 0;
      while (k < q.size() && cnt < 200) begin
        chkEq({tag, " R11 busy during send"}, int'(busy), 1);
        txReady = ((cyc % 3) != 2); cyc++;
        if (txValid && txReady) begin
          chkEq({tag, " R1 R2 R4 frame byte"}, int'(txByte), int'(q[k]));
          k++;
        end
        cnt++;
        @(negedge clk);
      end
      txReady = 1'b0;
      chkEq({tag, " R2 no byte after frame"}, int'(txValid), 0);
      for (int i = 0; i < sN[a]; i++) begin
        rxDataValid = 1'b1; rxData = dv(a, i);
        @(negedge clk);
      end
      rxDataValid = 1'b0;
      rxStatusValid = 1'b1; rxStatus = 2'(sSt[a]); rxReply = 8'(sRep[a]);
      start = 1'b0;
      @(negedge clk);
      rxStatusValid = 1'b0;
      judge(sSt[a], sRep[a], kd >= 2, act, res);
      if (act != 0 && a == 3) begin act = 0; res = 2; end  // R8
      if (act == 0) begin
        expLen = 0;
        if (res == 0 && kd == 0) expLen = (sN[a] < ln) ? sN[a] : ln;
        if (res == 0 && kd == 2) expLen = (sN[a] < 1) ? sN[a] : 1;
        chkEq({tag, " R12 done pulse"}, int'(done), 1);
        chkEq({tag, " R11 busy cleared"}, int'(busy), 0);
        chkEq({tag, " R6 R7 R8 R9 result"}, int'(result), res);
        chkEq({tag, " R10 rdLen"}, int'(rdLen), expLen);
        for (int j = 0; j < expLen; j++)
          chkEq({tag, " R10 rdData"}, int'(rdData[j*8 +: 8]), int'(dv(a, j)));
        @(negedge clk);
        chkEq({tag, " R12 done single"}, int'(done), 0);
        repeat (3) @(negedge clk);
        chkEq({tag, " R12 result held"}, int'(result), res);
        chkEq({tag, " R12 rdLen held"}, int'(rdLen), expLen);
        chkEq({tag, " R11 stays idle"}, int'(busy), 0);
        return;
      end else if (act == 1) begin
        chkEq({tag, " R5 immediate retry"}, int'(txValid), 1);
      end else begin
        cnt = 0;
        while (!txValid && cnt < BO_CYC + 10) begin
          cnt++;
          @(negedge clk);
        end
        chkEq({tag, " R7 back-off length"}, cnt, BO_CYC);
      end
    end
  endtask

  task automatic doReject(input string tag, input int kd, input int ln);
    @(negedge clk);
    kind = 2'(kd); len = 5'(ln); i2cStart = 1'b0; i2cStop = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chkEq({tag, " R3 done"}, int'(done), 1);
    chkEq({tag, " R3 result"}, int'(result), 4);
    chkEq({tag, " R3 not busy"}, int'(busy), 0);
    chkEq({tag, " R3 no tx"}, int'(txValid), 0);
    @(negedge clk);
    chkEq({tag, " R3 still quiet"}, int'(txValid | busy), 0);
  endtask

  logic [MAXB*8-1:0] pay;

  initial begin
    for (int i = 0; i < MAXB; i++) pay[i*8 +: 8] = 8'(8'hC3 ^ (i * 29));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R12 reset busy", int'(busy), 0);
    chkEq("R12 reset done", int'(done), 0);
    chkEq("R12 reset txValid", int'(txValid), 0);
    chkEq("R12 reset result", int'(result), 0);
    chkEq("R12 reset rdLen", int'(rdLen), 0);

    setAtt(0, 0, 8'h00, 5);
    doTxn("natRd truncate", 0, 0, 0, 16'h1234, 3, pay, 1'b1);
    setAtt(0, 0, 8'h00, 0);
    doTxn("natWr 16", 1, 0, 0, 16'hABCD, 16, pay, 1'b0);
    doReject("natWr 17", 1, 17);
    doReject("natRd 0", 0, 0);
    setAtt(0, 2, 8'h00, 0); setAtt(1, 0, 8'h20, 0); setAtt(2, 0, 8'h80, 1);
    doTxn("natRd busy defer ack", 0, 0, 0, 16'h0202, 2, pay, 1'b0);
    setAtt(0, 0, 8'h10, 0);
    doTxn("natWr nack", 1, 0, 0, 16'h0100, 1, pay, 1'b0);
    setAtt(0, 1, 8'h00, 0);
    doTxn("natRd timeout", 0, 0, 0, 16'h0300, 4, pay, 1'b0);
    setAtt(0, 3, 8'h00, 0);
    doTxn("natRd chan error", 0, 0, 0, 16'h0301, 4, pay, 1'b0);
    for (int a = 0; a < 4; a++) setAtt(a, 2, 8'h00, 0);
    doTxn("busy x4", 0, 0, 0, 16'h0400, 1, pay, 1'b0);
    for (int a = 0; a < 4; a++) setAtt(a, 0, 8'h20, 0);
    doTxn("defer x4", 1, 0, 0, 16'h0401, 2, pay, 1'b0);
    setAtt(0, 0, 8'h00, 2);
    doTxn("i2cRd start", 2, 1, 0, 16'h0050, 1, pay, 1'b0);
    setAtt(0, 0, 8'h80, 0); setAtt(1, 0, 8'h00, 0);
    doTxn("i2cWr i2c defer", 3, 0, 0, 16'h0050, 1, 128'h5A, 1'b0);
    setAtt(0, 0, 8'h40, 0);
    doTxn("i2cRd stop nack", 2, 0, 1, 16'h0050, 1, pay, 1'b0);
    setAtt(0, 0, 8'h00, 3);
    doTxn("i2cRd mid", 2, 0, 0, 16'h0050, 1, pay, 1'b0);
    setAtt(0, 0, 8'h00, 0);
    doTxn("i2cWr stop", 3, 0, 1, 16'h0050, 1, pay, 1'b0);
    setAtt(0, 0, 8'h30, 0);
    doTxn("natRd reserved", 0, 0, 0, 16'h0500, 1, pay, 1'b0);
    setAtt(0, 0, 8'hC0, 0);
    doTxn("i2cWr reserved", 3, 1, 0, 16'h0050, 1, pay, 1'b0);
    setAtt(0, 0, 8'h90, 0);
    doTxn("i2cRd native nack", 2, 0, 0, 16'h0050, 1, pay, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule